// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block carries one companded 8-bit sample per frame in each direction over a bit-clocked serial link. On the transmit side it shifts a held code byte out, most significant bit first, on a data pin with a separate output-enable. Together they form a three-state driver. It also pulls an open-drain slot indicator low while the transmit slot is open. On the receive side it assembles a byte from a serial data input and presents it with a single-cycle strobe.

The bit clocks, frame syncs and receive data are all sampled by a faster system clock. They pass through one synchronizer chain of equal depth, so their relative timing is preserved, and then go through edge detection. The width of each transmit sync decides whether the link runs with short (single bit period) or long (three or more bit periods) frame syncs. Each mode has its own rules for when the driver turns on and off and when receive bits are taken. A static select lets the receive direction run either from its own bit clock or from the transmit bit clock.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset, `long_mode` is 0 (short mode), `dx_oe` and `slot_pull` are 0, and `rx_valid` is 0.
- R2: At the end of every transmit sync, `long_mode` becomes 1 if the sync was high at LONG_MIN (default 3) or more falling transmit bit-clock edges, and 0 otherwise. It changes at no other time, and each frame uses the mode in force when its sync starts.
- R3: Short transmit: a falling bit-clock edge with the transmit sync high arms the slot. The next rising edge opens the slot and drives bit 7. The next seven rising edges drive bits 6 down to 0. The falling edge after the eighth rising edge closes the slot.
- R4: Short receive: a falling receive bit-clock edge with the receive sync high arms reception. The next eight falling edges latch bits 7 down to 0 from `dr_in`.
- R5: Long transmit: the slot opens at the later of the transmit sync rise and a bit-clock rise, driving bit 7. The following rising edges drive the remaining bits, MSB first.
- R6: Long transmit: the slot closes at the later of two events: the falling bit-clock edge after the eighth rising edge, or the transmit sync going low.
- R7: Long receive: a rising edge of the receive sync causes the next eight falling bit-clock edges to latch bits 7 down to 0.
- R8: The byte sent in a frame is the value of `tx_code` that was captured at the start of the previous frame.
- R9: `dx_oe` stays 0 until the second transmit sync after reset; from that sync on it follows the slot.
- R10: `slot_pull` is 1 exactly while the transmit slot is open, including the frames in which `dx_oe` is still held off.
- R11: With `sync_mode` = 1 the receiver is clocked by `bclk_tx`, and `bclk_rx` is ignored. With `sync_mode` = 0 it uses `bclk_rx`.
- R12: A completed byte appears on `rx_byte` with `rx_valid` high for exactly one cycle. A new receive sync in the middle of a byte discards the partial byte and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial-side inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | 1: receiver uses the transmit bit clock |
| bclk_tx | input | 1 | Transmit bit clock |
| bclk_rx | input | 1 | Receive bit clock (used when `sync_mode` = 0) |
| fs_tx | input | 1 | Transmit frame sync |
| fs_rx | input | 1 | Receive frame sync |
| dr_in | input | 1 | Serial receive data |
| tx_code | input | CODE_W | Code byte for the next frame |
| dx_data | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Enable for the transmit data driver |
| slot_pull | output | 1 | 1 = pull the open-drain slot indicator low |
| long_mode | output | 1 | Current frame-sync mode, 1 = long |
| rx_byte | output | CODE_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |

## Verification
The bench targets the two-sided close rule in long mode. It uses syncs shorter than, equal to and longer than eight bit periods. A design that ignores the sync level would drop the driver while the sync is still high, and one that ignores the clock would hold it for too short a time. It sends long syncs that rise while the bit clock is low, which catches a design that opens the slot on the sync edge alone. It tests the power-up hold-off, where a design that counts one sync short would drive a stale byte in the first frame. It also covers the one-frame lag between `tx_code` and the line, which an off-by-one would shift by a frame. Further directed cases cover mode changes in both directions. They include a receive sync that arrives in the middle of a byte, where a design that kept the partial count would report a corrupted byte. They also cover a dead receive bit clock with each setting of `sync_mode`.

// File: rtl/pcmsp_pkg.sv
package pcmsp_pkg;

   typedef enum logic [1:0] {
      TX_IDLE   = 2'd0,
      TX_PEND   = 2'd1,
      TX_ARMED  = 2'd2,
      TX_ACTIVE = 2'd3
   } tx_state_t;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_PEND  = 2'd1,
      RX_SHIFT = 2'd2
   } rx_state_t;

endpackage

// File: rtl/pcmsp_sync.sv
module pcmsp_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] q_d
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pcmsp_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES:0] chain;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-1:0], d[i]};
      end

      assign q[i]   = chain[STAGES-1];
      assign q_d[i] = chain[STAGES];
   end

endmodule

// File: rtl/pcmsp_tx.sv
module pcmsp_tx
   import pcmsp_pkg::*;
#(
   parameter int CODE_W   = 8,
   parameter int LONG_MIN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              b,
   input  logic              b_d,
   input  logic              f,
   input  logic              f_d,
   input  logic [CODE_W-1:0] tx_code,
   output logic              dx_data,
   output logic              dx_oe,
   output logic              slot,
   output logic              long_mode
);

   localparam int CNT_W = $clog2(CODE_W + 1);
   localparam int FW    = $clog2(LONG_MIN + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CODE_W);
   localparam logic [FW-1:0]    FCNT_SAT = FW'(LONG_MIN);

   logic rise_b, fall_b, rise_f, fall_f;
   assign rise_b = b & ~b_d;
   assign fall_b = ~b & b_d;
   assign rise_f = f & ~f_d;
   assign fall_f = ~f & f_d;

   tx_state_t          st;
   logic [CODE_W-1:0]  shreg, hold;
   logic [CNT_W-1:0]   bit_cnt;
   logic [FW-1:0]      fcnt;
   logic [1:0]         seen;
   logic               done_q, slot_q, dx_q, long_q, fr_long;

   // sync width measurement and mode decision
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt   <= '0;
         long_q <= 1'b0;
         seen   <= 2'd0;
      end else begin
         if (rise_f && seen != 2'd2) seen <= seen + 2'd1;
         if (rise_f)
            fcnt <= '0;
         else if (fall_b && f && fcnt != FCNT_SAT)
            fcnt <= fcnt + 1'b1;
         if (fall_f) long_q <= (fcnt >= FCNT_SAT);
      end
   end

   // frame sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= TX_IDLE;
         shreg   <= '0;
         hold    <= '0;
         bit_cnt <= '0;
         done_q  <= 1'b0;
         slot_q  <= 1'b0;
         dx_q    <= 1'b0;
         fr_long <= 1'b0;
      end else if (rise_f) begin
         done_q  <= 1'b0;
         fr_long <= long_q;
         if (long_q) begin
            shreg <= hold;
            hold  <= tx_code;
            if (b) begin
               slot_q  <= 1'b1;
               dx_q    <= hold[CODE_W-1];
               bit_cnt <= CNT_W'(1);
               st      <= TX_ACTIVE;
            end else begin
               slot_q  <= 1'b0;
               bit_cnt <= '0;
               st      <= TX_ARMED;
            end
         end else begin
            slot_q  <= 1'b0;
            bit_cnt <= '0;
            st      <= TX_PEND;
         end
      end else begin
         unique case (st)
            TX_IDLE: ;
            TX_PEND: begin
               if (fall_b && f) begin
                  shreg <= hold;
                  hold  <= tx_code;
                  st    <= TX_ARMED;
               end
            end
            TX_ARMED: begin
               if (rise_b) begin
                  slot_q  <= 1'b1;
                  dx_q    <= shreg[CODE_W-1];
                  bit_cnt <= CNT_W'(1);
                  st      <= TX_ACTIVE;
               end
            end
            TX_ACTIVE: begin
               if (rise_b && bit_cnt != LAST_BIT) begin
                  dx_q    <= shreg[CODE_W-2];
                  shreg   <= shreg << 1;
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (bit_cnt == LAST_BIT) begin
                  if (fall_b) done_q <= 1'b1;
                  if (fr_long ? ((done_q || fall_b) && !f) : fall_b) begin
                     slot_q <= 1'b0;
                     st     <= TX_IDLE;
                  end
               end
            end
            default: st <= TX_IDLE;
         endcase
      end
   end

   assign dx_data   = dx_q;
   assign slot      = slot_q;
   assign dx_oe     = slot_q & (seen == 2'd2);
   assign long_mode = long_q;

   // the slot opens only on a sampled rising edge of bit clock or sync
   p_open_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slot_q) |-> $past(rise_b || rise_f));

   // driven bit only moves on a bit-clock rise or a new frame
   p_bit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q && !rise_b && !rise_f) |=> $stable(dx_q));

   // at most CODE_W bits go out per slot
   p_bit_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q |-> (bit_cnt != '0 && bit_cnt <= LAST_BIT));

   // mode only changes at the end of a sync
   p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_f |=> $stable(long_q));

endmodule

// File: rtl/pcmsp_rx.sv
module pcmsp_rx
   import pcmsp_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              b,
   input  logic              b_d,
   input  logic              f,
   input  logic              f_d,
   input  logic              dr,
   input  logic              long_mode,
   output logic [CODE_W-1:0] rx_byte,
   output logic              rx_valid
);

   localparam int CW = $clog2(CODE_W);
   localparam logic [CW-1:0] LAST = CW'(CODE_W - 1);

   logic fall_b, rise_f;
   assign fall_b = ~b & b_d;
   assign rise_f = f & ~f_d;

   rx_state_t         st;
   logic [CW-1:0]     cnt;
   logic [CODE_W-1:0] sh, byte_q;
   logic              valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= RX_IDLE;
         cnt     <= '0;
         sh      <= '0;
         byte_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (rise_f) begin
            cnt <= '0;
            st  <= long_mode ? RX_SHIFT : RX_PEND;
         end else begin
            unique case (st)
               RX_IDLE: ;
               RX_PEND: begin
                  if (fall_b && f) begin
                     cnt <= '0;
                     st  <= RX_SHIFT;
                  end
               end
               RX_SHIFT: begin
                  if (fall_b) begin
                     sh <= {sh[CODE_W-2:0], dr};
                     if (cnt == LAST) begin
                        byte_q  <= {sh[CODE_W-2:0], dr};
                        valid_q <= 1'b1;
                        st      <= RX_IDLE;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

   assign rx_byte  = byte_q;
   assign rx_valid = valid_q;

   p_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q);

   p_done_leaves_shift_r12: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> st != RX_SHIFT || $past(rise_f));

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
   parameter int CODE_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int LONG_MIN    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_mode,
   input  logic              bclk_tx,
   input  logic              bclk_rx,
   input  logic              fs_tx,
   input  logic              fs_rx,
   input  logic              dr_in,
   input  logic [CODE_W-1:0] tx_code,
   output logic              dx_data,
   output logic              dx_oe,
   output logic              slot_pull,
   output logic              long_mode,
   output logic [CODE_W-1:0] rx_byte,
   output logic              rx_valid
);

   localparam int NSIG = 5;
   localparam int I_BT = 0;
   localparam int I_FT = 1;
   localparam int I_BR = 2;
   localparam int I_FR = 3;
   localparam int I_DR = 4;

   if (CODE_W < 2) begin : g_bad_width
      $error("pcm_slot_port: CODE_W must be at least 2");
   end
   if (LONG_MIN < 2) begin : g_bad_long
      $error("pcm_slot_port: LONG_MIN must be at least 2");
   end

   logic            rx_clk_raw;
   logic [NSIG-1:0] raw, s_q, s_d;

   assign rx_clk_raw = sync_mode ? bclk_tx : bclk_rx;
   assign raw = {dr_in, fs_rx, rx_clk_raw, fs_tx, bclk_tx};

   pcmsp_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (s_q),
      .q_d   (s_d)
   );

   logic mode_w;

   pcmsp_tx #(.CODE_W(CODE_W), .LONG_MIN(LONG_MIN)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .b         (s_q[I_BT]),
      .b_d       (s_d[I_BT]),
      .f         (s_q[I_FT]),
      .f_d       (s_d[I_FT]),
      .tx_code   (tx_code),
      .dx_data   (dx_data),
      .dx_oe     (dx_oe),
      .slot      (slot_pull),
      .long_mode (mode_w)
   );

   pcmsp_rx #(.CODE_W(CODE_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .b         (s_q[I_BR]),
      .b_d       (s_d[I_BR]),
      .f         (s_q[I_FR]),
      .f_d       (s_d[I_FR]),
      .dr        (s_q[I_DR]),
      .long_mode (mode_w),
      .rx_byte   (rx_byte),
      .rx_valid  (rx_valid)
   );

   assign long_mode = mode_w;

   // the data driver is never on outside the slot window
   p_oe_in_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dx_oe) |-> slot_pull);

endmodule

// File: tb/pcm_slot_port_test.sv
module pcm_slot_port_test;

   localparam int CLK_PERIOD = 10;
   localparam int H = 4;
   localparam int W = 8;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic rst_n, sync_mode, bclk_tx, bclk_rx, fs_tx, fs_rx, dr_in;
   logic [W-1:0] tx_code;
   logic dx_data, dx_oe, slot_pull, long_mode, rx_valid;
   logic [W-1:0] rx_byte;

   pcm_slot_port uut (
      .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .bclk_tx(bclk_tx),
      .bclk_rx(bclk_rx), .fs_tx(fs_tx), .fs_rx(fs_rx), .dr_in(dr_in),
      .tx_code(tx_code), .dx_data(dx_data), .dx_oe(dx_oe),
      .slot_pull(slot_pull), .long_mode(long_mode), .rx_byte(rx_byte),
      .rx_valid(rx_valid)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int vcount   = 0;
   logic [W-1:0] vbyte;
   bit   rx_dead = 1'b0;
   int   nsync   = 0;
   logic [W-1:0] prev_code = '0;
   bit   model_long = 1'b0;

   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         vcount = vcount + 1;
         vbyte  = rx_byte;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic exp_bit(input logic [W-1:0] code, input int k);
      return code[W-1-k];
   endfunction

   task automatic bit_period(input logic fh, input logic fl, input logic d,
                             output logic dxh, output logic oeh,
                             output logic slh, output logic oel);
      bclk_tx = 1'b1; bclk_rx = !rx_dead;
      fs_tx = fh; fs_rx = fh; dr_in = d;
      repeat (H) @(negedge clk);
      dxh = dx_data; oeh = dx_oe; slh = slot_pull;
      bclk_tx = 1'b0; bclk_rx = 1'b0;
      fs_tx = fl; fs_rx = fl;
      repeat (H) @(negedge clk);
      oel = dx_oe;
   endtask

   task automatic short_frame(input logic [W-1:0] code, input logic [W-1:0] rxb,
                              input bit chk_en);
      logic dxh, oeh, slh, oel;
      bit exp_oe;
      tx_code = code;
      vcount = 0;
      nsync++;
      exp_oe = (nsync >= 2);
      bit_period(1'b1, 1'b1, 1'b0, dxh, oeh, slh, oel);
      if (chk_en) chk(oel == 1'b0, "R3 closed while armed", oel, 0);
      for (int k = 0; k < W; k++) begin
         bit_period(1'b0, 1'b0, rxb[W-1-k], dxh, oeh, slh, oel);
         if (chk_en) begin
            if (exp_oe) chk(dxh == exp_bit(prev_code, k), "R3 R8 short tx bit", dxh, exp_bit(prev_code, k));
            chk(oeh == exp_oe, "R9 short oe", oeh, exp_oe);
            chk(slh == 1'b1, "R10 slot open", slh, 1);
            if (k == W-1) chk(oel == 1'b0, "R3 close after eighth", oel, 0);
         end
      end
      for (int k = 0; k < 2; k++) begin
         bit_period(1'b0, 1'b0, 1'b0, dxh, oeh, slh, oel);
         if (chk_en) chk(slh == 1'b0, "R10 slot closed", slh, 0);
      end
      if (chk_en) begin
         chk(vcount == 1, "R4 one byte", vcount, 1);
         chk(vbyte == rxb, "R4 short rx byte", vbyte, rxb);
      end
      prev_code = code;
   endtask

   task automatic long_frame(input logic [W-1:0] code, input logic [W-1:0] rxb,
                             input int len, input bit early, input bit chk_en);
      logic dxh, oeh, slh, oel;
      bit exp_oe;
      int last;
      tx_code = code;
      vcount = 0;
      nsync++;
      exp_oe = (nsync >= 2);
      last = ((len > W) ? len : W) + 1;
      if (early) bit_period(1'b0, 1'b1, 1'b0, dxh, oeh, slh, oel);
      for (int p = 0; p <= last; p++) begin
         logic fv;
         fv = (p < len);
         bit_period(fv, fv, (p < W) ? rxb[W-1-p] : 1'b0, dxh, oeh, slh, oel);
         if (chk_en) begin
            if (p < W) begin
               if (exp_oe) chk(dxh == exp_bit(prev_code, p), "R5 R8 long tx bit", dxh, exp_bit(prev_code, p));
               chk(oeh == exp_oe, "R9 long oe", oeh, exp_oe);
               chk(slh == 1'b1, "R10 long slot", slh, 1);
               if (p == W-1) chk(oel == ((len >= W) ? exp_oe : 1'b0), "R6 close at clock or sync", oel, (len >= W) ? exp_oe : 0);
            end else if (p < len) begin
               chk(oeh == exp_oe, "R6 held by sync", oeh, exp_oe);
            end else begin
               chk(oeh == 1'b0 && slh == 1'b0, "R6 closed after sync", {oeh, slh}, 0);
            end
         end
      end
      if (chk_en) begin
         chk(vcount == 1, "R7 one byte", vcount, 1);
         chk(vbyte == rxb, "R7 long rx byte", vbyte, rxb);
      end
      prev_code = code;
   endtask

   task automatic go_mode(input bit want_long);
      if (want_long != model_long) begin
         if (want_long) long_frame(8'h00, 8'h00, 4, 1'b0, 1'b0);
         else           short_frame(8'h00, 8'h00, 1'b0);
         model_long = want_long;
         chk(long_mode == want_long, "R2 mode after sync", long_mode, want_long);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic dxh, oeh, slh, oel;
      void'($urandom(32'd4242));
      rst_n = 1'b0; sync_mode = 1'b0; bclk_tx = 1'b0; bclk_rx = 1'b0;
      fs_tx = 1'b0; fs_rx = 1'b0; dr_in = 1'b0; tx_code = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(long_mode == 1'b0, "R1 reset mode", long_mode, 0);
      chk(dx_oe == 1'b0, "R1 reset oe", dx_oe, 0);
      chk(slot_pull == 1'b0, "R1 reset slot", slot_pull, 0);
      chk(rx_valid == 1'b0, "R1 reset valid", rx_valid, 0);

      // first sync: slot opens but the driver stays off (R9, R10)
      short_frame(8'hA5, 8'h3C, 1'b1);
      // second sync: driver on, previous frame's code on the line (R8)
      short_frame(8'h5A, 8'hC3, 1'b1);
      short_frame(8'hFF, 8'h01, 1'b1);
      short_frame(8'h00, 8'h80, 1'b1);

      // receive sync arriving mid-byte restarts the byte (R12)
      vcount = 0;
      tx_code = 8'h00;
      nsync++;
      bit_period(1'b1, 1'b1, 1'b0, dxh, oeh, slh, oel);
      for (int k = 0; k < 3; k++) bit_period(1'b0, 1'b0, 1'b1, dxh, oeh, slh, oel);
      nsync++;
      bit_period(1'b1, 1'b1, 1'b0, dxh, oeh, slh, oel);
      for (int k = 0; k < W; k++) bit_period(1'b0, 1'b0, 8'h69 >> (W-1-k), dxh, oeh, slh, oel);
      for (int k = 0; k < 2; k++) bit_period(1'b0, 1'b0, 1'b0, dxh, oeh, slh, oel);
      chk(vcount == 1, "R12 single strobe after restart", vcount, 1);
      chk(vbyte == 8'h69, "R12 restarted byte", vbyte, 8'h69);
      prev_code = 8'h00;

      // shared bit clock (R11)
      rx_dead = 1'b1;
      sync_mode = 1'b1;
      short_frame(8'h96, 8'hB4, 1'b1);
      chk(vbyte == 8'hB4, "R11 rx on transmit clock", vbyte, 8'hB4);
      sync_mode = 1'b0;
      short_frame(8'h11, 8'h77, 1'b0);
      chk(vcount == 0, "R11 dead receive clock", vcount, 0);
      rx_dead = 1'b0;

      // switch to long frames; mode follows sync width (R2)
      go_mode(1'b1);
      long_frame(8'hC6, 8'h2D, 3, 1'b0, 1'b1);
      long_frame(8'h3B, 8'hE1, 8, 1'b0, 1'b1);
      long_frame(8'h81, 8'h7E, 10, 1'b0, 1'b1);
      long_frame(8'h4D, 8'h92, 5, 1'b1, 1'b1);
      long_frame(8'hE7, 8'h18, 11, 1'b1, 1'b1);
      go_mode(1'b0);
      short_frame(8'h24, 8'h5B, 1'b1);

      // random frames with mixed modes
      for (int n = 0; n < 24; n++) begin
         bit want_long;
         logic [W-1:0] c, r;
         want_long = ($urandom % 3) == 0 ? ~model_long : model_long;
         c = W'($urandom);
         r = W'($urandom);
         go_mode(want_long);
         if (model_long) long_frame(c, r, 3 + int'($urandom % 9), bit'($urandom % 2), 1'b1);
         else            short_frame(c, r, 1'b1);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule